// File: doc/BRIEF.md
# Six-Bit Set/Clear GPIO Output Register Block

This block holds six general-purpose output levels behind a small 8-bit register bus. Software never writes the output word directly. It writes a mask to a set register, and every output whose mask bit is 1 goes high. It writes a mask to a clear register, and every output whose mask bit is 1 goes low. Mask bits that are 0 leave their outputs alone, so one bit can change without a read-modify-write.

The six pin levels come in through a two-flop synchroniser. Software can read them from a status register. The same synchronised levels are packed into an 8-bit interrupt-status byte. That byte uses a fixed, scrambled bit order, which a downstream transport forwards to the host unchanged.

The bus has an address, a write strobe, write data and combinational read data. Each write takes effect at the clock edge where the strobe is sampled. Reset is synchronous and active low.

Top module: `gpio_setclr_top`

## Requirements
- R1: While reset is held low at a clock edge, all six outputs go to 0 and both synchroniser stages go to 0. After reset, the outputs, the status read and the interrupt byte are all 0.
- R2: A write to address 0 (the set register) makes every output whose data bit (5..0) is 1 read high after that edge. Outputs whose data bit is 0 keep their level.
- R3: A write to address 1 (the clear register) makes every output whose data bit (5..0) is 1 read low after that edge. Outputs whose data bit is 0 keep their level.
- R4: Data bits 7 and 6 of a set or clear write have no effect on any output.
- R5: Reading address 2 (the status register) returns the pin levels in bits 5..0, with bit n for pin n, and 0 in bits 7..6. A pin change shows up exactly two clock edges after it is sampled.
- R6: The interrupt byte is, from bit 7 down to bit 0: 0, pin5, pin4, pin3, pin0, 0, pin2, pin1. It uses the same synchronised levels that the status register returns.
- R7: Reading address 0 or 1 returns the output levels in bits 5..0 and 0 in bits 7..6. Reading address 3 returns 0. Writes to address 2 or 3 leave the outputs unchanged.
- R8: Set and clear writes on consecutive cycles take effect in the order they arrive, so the later write decides any bit that both masks touch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| gpio_in | input | 6 | Asynchronous pin levels |
| gpio_out | output | 6 | Output levels |
| irq_byte | output | 8 | Packed interrupt-status byte |

## Verification
A walked vector list applies set and clear masks of several kinds:
- a single bit;
- a nibble;
- all ones;
- alternating bits;
- masks that touch only bits 7..6.

Each mask is applied on top of a known output word, which separates a true set/clear from a plain overwrite and from an inverted mask. Back-to-back set then clear, and clear then set, on overlapping bits shows whether writes land in order. One-hot pin patterns on the inputs give each interrupt-byte bit its own position, so any swapped lane shows up. A pin change sampled one edge and then two edges later pins down the synchroniser latency.

// File: rtl/gpio_sc_pkg.sv
// Package: shared widths and the register address map of the set/clear GPIO block.
// Assumes a 2-bit register address and an 8-bit data bus.
package gpio_sc_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;
    localparam int PIN_N  = 6;

    // Register selects; the numeric values are the bus addresses.
    typedef enum logic [ADDR_W-1:0] {
        SEL_SET  = 2'd0,
        SEL_CLR  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/gpio_sc_regdec.sv
// Module: register address decoder.
// Turns the bus address and write strobe into one-cycle set and clear strobes
// and a read select. Assumes only one register is addressed per cycle.
module gpio_sc_regdec
    import gpio_sc_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic          wr,
    output logic          set_stb,
    output logic          clr_stb,
    output reg_sel_e      rsel
);

    // Map the raw address onto the register select.
    always_comb begin
        rsel = reg_sel_e'(addr);
    end

    // Raise a strobe only for writes to the set or clear register.
    always_comb begin
        set_stb = wr && (rsel == SEL_SET);
        clr_stb = wr && (rsel == SEL_CLR);
    end

endmodule

// File: rtl/gpio_sc_outlatch.sv
// Module: output latch updated through masks.
// A set strobe ORs the mask into the held word; a clear strobe removes the
// mask bits from it. Assumes the two strobes are never high together.
module gpio_sc_outlatch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [N-1:0] mask,
    output logic [N-1:0] q
);

    logic [N-1:0] q_nxt;

    // Work out the next output word from the active strobe.
    always_comb begin
        q_nxt = q;
        if (set_stb) begin
            q_nxt = q | mask;
        end else if (clr_stb) begin
            q_nxt = q & ~mask;
        end
    end

    // Hold the output word; synchronous reset to all zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= q_nxt;
        end
    end

endmodule

// File: rtl/gpio_sc_sync.sv
// Module: multi-stage input synchroniser, one flop chain per bit.
// Assumes each input is a slow level; no glitch filtering is done.
module gpio_sc_sync #(
    parameter int N      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift the pin level through the chain; clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], d[b]};
            end
        end

        // Drive the output from the last stage.
        assign q[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/gpio_sc_irqmap.sv
// Module: packs the six synchronised pin levels into the interrupt byte.
// The lane order is fixed by the consumer of the byte. Assumes exactly six pins.
module gpio_sc_irqmap (
    input  logic [5:0] pins,
    output logic [7:0] irq
);

    // Put each pin on its fixed lane; lanes 7 and 2 stay zero.
    always_comb begin
        irq    = '0;
        irq[6] = pins[5];
        irq[5] = pins[4];
        irq[4] = pins[3];
        irq[3] = pins[0];
        irq[1] = pins[2];
        irq[0] = pins[1];
    end

endmodule

// File: rtl/gpio_setclr_top.sv
// Module: six-bit set/clear GPIO register block, the top level.
// Decodes the bus, holds the output word, synchronises the pins and builds
// the interrupt byte. Assumes DATA_W > PIN_N, so the upper data bits are spare.
module gpio_setclr_top
    import gpio_sc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_N-1:0]  gpio_in,
    output logic [PIN_N-1:0]  gpio_out,
    output logic [7:0]        irq_byte
);

    localparam int PAD_W = DATA_W - PIN_N;

    logic             set_stb;
    logic             clr_stb;
    reg_sel_e         rsel;
    logic [PIN_N-1:0] pin_sync;
    logic             unused_wdata_hi;

    // The spare upper data bits are not used by any register.
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:PIN_N];

    gpio_sc_regdec #(.AW(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .rsel    (rsel)
    );

    gpio_sc_outlatch #(.N(PIN_N)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (set_stb),
        .clr_stb (clr_stb),
        .mask    (bus_wdata[PIN_N-1:0]),
        .q       (gpio_out)
    );

    gpio_sc_sync #(.N(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gpio_in),
        .q     (pin_sync)
    );

    gpio_sc_irqmap u_irq (
        .pins (pin_sync),
        .irq  (irq_byte)
    );

    // Read mux: set/clear addresses return the output word, status returns the pins.
    always_comb begin
        unique case (rsel)
            SEL_SET, SEL_CLR: bus_rdata = {{PAD_W{1'b0}}, gpio_out};
            SEL_STAT:         bus_rdata = {{PAD_W{1'b0}}, pin_sync};
            default:          bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_setclr_chk.sv
// Module: assertion checker for gpio_setclr_top, attached with bind.
// Watches the ports only; keeps a small counter to know when the synchroniser is valid.
module gpio_setclr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic [5:0] gpio_in,
    input logic [5:0] gpio_out,
    input logic [7:0] irq_byte
);

    logic [1:0] since_rst;

    // Count edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (gpio_out == 6'h00));

    assert_set_drives_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=>
            ((gpio_out & $past(bus_wdata[5:0])) == $past(bus_wdata[5:0])));

    assert_set_keeps_zeros_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0) |=>
            (((gpio_out ^ $past(gpio_out)) & ~$past(bus_wdata[5:0])) == 6'h00));

    assert_clear_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=>
            ((gpio_out & $past(bus_wdata[5:0])) == 6'h00));

    assert_clear_keeps_zeros_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd1) |=>
            (((gpio_out ^ $past(gpio_out)) & ~$past(bus_wdata[5:0])) == 6'h00));

    assert_status_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd2 && since_rst >= 2'd2) |->
            (bus_rdata == {2'b00, $past(gpio_in, 2)}));

    assert_irq_lanes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd2) |->
            (irq_byte == {1'b0, bus_rdata[5], bus_rdata[4], bus_rdata[3],
                          bus_rdata[0], 1'b0, bus_rdata[2], bus_rdata[1]}));

    assert_other_writes_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr[1] == 1'b0) |=> $stable(gpio_out));

    assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1] == 1'b0) |-> (bus_rdata == {2'b00, gpio_out}));

endmodule

bind gpio_setclr_top gpio_setclr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_in   (gpio_in),
    .gpio_out  (gpio_out),
    .irq_byte  (irq_byte)
);

// File: tb/sim_gpio_setclr_top.sv
// Bench for gpio_setclr_top: a walked write-vector table, then directed tests.
// Inputs change and outputs are sampled on the falling edge.
module sim_gpio_setclr_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [5:0] gpio_in;
    logic [5:0] gpio_out;
    logic [7:0] irq_byte;

    int total = 0;
    int bad   = 0;

    // 50 MHz clock.
    always #10 clk = ~clk;

    gpio_setclr_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gpio_in   (gpio_in),
        .gpio_out  (gpio_out),
        .irq_byte  (irq_byte)
    );

    // Vector fields: {addr[1:0], wdata[7:0], expected gpio_out[5:0]}.
    localparam int NV = 11;
    localparam logic [15:0] VEC [0:NV-1] = '{
        {2'd0, 8'h05, 6'h05},   // R2 single bits
        {2'd0, 8'h30, 6'h35},   // R2 keeps earlier bits
        {2'd1, 8'h01, 6'h34},   // R3 one bit low
        {2'd0, 8'hC0, 6'h34},   // R4 spare bits on set
        {2'd1, 8'hC0, 6'h34},   // R4 spare bits on clear
        {2'd0, 8'hFF, 6'h3F},   // R2 all ones
        {2'd1, 8'h2A, 6'h15},   // R3 alternating
        {2'd2, 8'hFF, 6'h15},   // R7 write to status ignored
        {2'd3, 8'h00, 6'h15},   // R7 write to unused address ignored
        {2'd1, 8'h3F, 6'h00},   // R3 all low
        {2'd0, 8'h2A, 6'h2A}    // R2 from zero
    };

    function automatic logic [7:0] irq_model(input logic [5:0] p);
        return {1'b0, p[5], p[4], p[3], p[0], 1'b0, p[2], p[1]};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one write on the falling edge; return on the next falling edge.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00; gpio_in = 6'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 out", {2'b00, gpio_out}, 8'h00);
        bus_read(2'd2, rd); check("R1 status", rd, 8'h00);
        check("R1 irq", irq_byte, 8'h00);

        // Walk the vector table (R2 R3 R4 R7)
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][15:14], VEC[i][13:6]);
            check("R2/R3/R4/R7 vector", {2'b00, gpio_out}, {2'b00, VEC[i][5:0]});
        end

        // R7 readback and unused address
        bus_read(2'd0, rd); check("R7 read set addr", rd, 8'h2A);
        bus_read(2'd1, rd); check("R7 read clear addr", rd, 8'h2A);
        bus_read(2'd3, rd); check("R7 read unused", rd, 8'h00);

        // R8 back-to-back order
        bus_write(2'd0, 8'h3F);
        bus_write(2'd1, 8'h0F);
        check("R8 set then clear", {2'b00, gpio_out}, 8'h30);
        bus_write(2'd1, 8'h3F);
        bus_write(2'd0, 8'h05);
        check("R8 clear then set", {2'b00, gpio_out}, 8'h05);

        // R5 synchroniser latency
        bus_addr = 2'd2;
        gpio_in  = 6'h2D;
        @(negedge clk);
        bus_read(2'd2, rd); check("R5 one edge old", rd, 8'h00);
        @(negedge clk);
        bus_read(2'd2, rd); check("R5 two edges new", rd, 8'h2D);

        // R6 lane map with one-hot and full patterns
        for (int p = 0; p < 7; p++) begin
            logic [5:0] pat;
            pat = (p == 6) ? 6'h3F : 6'(1 << p);
            gpio_in = pat;
            @(negedge clk);
            @(negedge clk);
            check("R6 irq lanes", irq_byte, irq_model(pat));
            bus_read(2'd2, rd); check("R5 status", rd, {2'b00, pat});
        end

        // R1 reset mid-run
        bus_write(2'd0, 8'h3F);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset clears out", {2'b00, gpio_out}, 8'h00);
        bus_read(2'd2, rd); check("R1 reset clears status", rd, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule